// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an asynchronous static RAM of 65,536 four-bit words. The host asks for one word per transaction: a request pulse, a write flag, a 16-bit address and, for writes, four data bits. The controller then runs the strobe sequence the memory needs. Every timing minimum is met by counting whole clock cycles. The cycle counts come from nanosecond parameters and a clock-period parameter, and each is rounded up.

A write lowers write enable first and waits out the bus turnaround. It then lowers chip select, so the memory never drives the data pins while the controller does. Only at that point does the controller turn on its data driver. A read holds chip select low with write enable high and samples the memory data on the last strobe cycle. Both operations end with one recovery cycle, in which the address, and for a write the driven data, stay stable. Busy covers the whole transaction, and done marks its last cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and right after it: chip select and write enable are high (inactive), the data driver enable is 0, busy and done are 0, and read data is 0.
- R2: A read accepted at a clock edge holds chip select low and write enable high for exactly 3 cycles, starting the next cycle. The data driver stays off throughout.
- R3: The memory data present on the last read strobe cycle appears on read data in the following (recovery) cycle. It is held until the next read completes.
- R4: A write accepted at a clock edge lowers write enable for 2 turnaround cycles with chip select still high. Both strobes are then low together for 3 cycles and rise at the same edge.
- R5: The data driver enable is 1 only during the 3 write strobe cycles and the write's recovery cycle. While it is 1, the memory output data equals the write data captured with the request.
- R6: The memory address equals the address captured with the request from the first cycle after acceptance through the recovery cycle.
- R7: Busy is 1 from the cycle after acceptance until the recovery cycle ends. Done is 1 only in the recovery cycle, for exactly one cycle per transaction.
- R8: A request seen while busy is 1 is ignored: it starts no access and changes no memory word.
- R9: The data driver is never turned on until chip select has been high for at least 2 consecutive cycles, including directly after a read.
- R10: A request held high is accepted again on each cycle the controller is idle, so back-to-back transactions are separated by exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transaction request, sampled while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| rd_data | output | 4 | Last read result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data output driver |
| mem_dq_i | input | 4 | Data from the memory |

## Verification
Isolated writes and reads at address 0, the top address and scattered patterns check the bare strobe shapes. Reading an address that was never written separates the real memory path from stale read data. A request held high for many cycles shows the single idle cycle between accepted operations. A write issued on the first idle cycle after a read is the tightest case for bus turnaround. A second request raised during a busy write, followed by a read of its address, shows whether that request was dropped or leaked into memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WTURN = 3'd1,
    ST_WSTRB = 3'd2,
    ST_RSTRB = 3'd3,
    ST_RECOV = 3'd4
  } ctl_state_t;

  // Whole clock cycles that cover a time span, never fewer than one.
  function automatic int span_cycles(input int span_ns, input int clk_ns);
    int c;
    c = (span_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rstsync.sv
module asram_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int WR_CYC   = 3,
  parameter int RD_CYC   = 3,
  parameter int TURN_CYC = 2,
  localparam int MAX_CYC = max2(max2(WR_CYC, RD_CYC), TURN_CYC),
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_wr,
  output logic accept,
  output logic capture,
  output logic cs_n,
  output logic we_n,
  output logic dq_oe,
  output logic busy,
  output logic done
);

  ctl_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            wr_q, wr_d;
  logic            cs_n_d, we_n_d, dq_oe_d, busy_d, done_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (req_wr) begin
            state_d = ST_WTURN;
            cnt_d   = CW'(TURN_CYC - 1);
          end else begin
            state_d = ST_RSTRB;
            cnt_d   = CW'(RD_CYC - 1);
          end
        end
      end
      ST_WTURN: begin
        if (cnt_q == '0) begin
          state_d = ST_WSTRB;
          cnt_d   = CW'(WR_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WSTRB: begin
        if (cnt_q == '0) state_d = ST_RECOV;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RSTRB: begin
        if (cnt_q == '0) begin
          state_d = ST_RECOV;
          capture = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registered strobes decoded from the next state
  always_comb begin
    wr_d    = accept ? req_wr : wr_q;
    cs_n_d  = !((state_d == ST_WSTRB) || (state_d == ST_RSTRB));
    we_n_d  = !((state_d == ST_WTURN) || (state_d == ST_WSTRB));
    dq_oe_d = (state_d == ST_WSTRB) || ((state_d == ST_RECOV) && wr_d);
    busy_d  = (state_d != ST_IDLE);
    done_d  = (state_d == ST_RECOV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      cs_n    <= cs_n_d;
      we_n    <= we_n_d;
      dq_oe   <= dq_oe_d;
      busy    <= busy_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW = 16,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdat_d, rdat_d;

  always_comb begin
    addr_d = accept  ? req_addr  : mem_addr;
    wdat_d = accept  ? req_wdata : mem_dq_o;
    rdat_d = capture ? mem_dq_i  : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
      rd_data  <= '0;
    end else begin
      mem_addr <= addr_d;
      mem_dq_o <= wdat_d;
      rd_data  <= rdat_d;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 4,
  parameter int CLK_NS    = 10,
  parameter int T_WCYC_NS = 25,
  parameter int T_RCYC_NS = 25,
  parameter int T_CSZ_NS  = 15,
  parameter int T_WEZ_NS  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int WR_CYC   = span_cycles(T_WCYC_NS, CLK_NS);
  localparam int RD_CYC   = span_cycles(T_RCYC_NS, CLK_NS);
  localparam int TURN_CYC = span_cycles(max2(T_CSZ_NS, T_WEZ_NS), CLK_NS);

  logic rst_sync_n;
  logic accept, capture;

  asram_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  asram_seq #(
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .req_wr  (req_wr),
    .accept  (accept),
    .capture (capture),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .dq_oe   (mem_dq_oe),
    .busy    (busy),
    .done    (done)
  );

  asram_dpath #(
    .AW (AW),
    .DW (DW)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW       = 16,
  parameter int DW       = 4,
  parameter int TURN_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] rd_data
);

  // Cycles chip select has been high, saturating
  logic [7:0] csh_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              csh_cnt <= '0;
    else if (!mem_cs_n)      csh_cnt <= '0;
    else if (csh_cnt != 8'hFF) csh_cnt <= csh_cnt + 8'd1;
  end

  // R4: chip select falls only with write enable already low, or in a read
  p_we_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && !mem_we_n) |-> $past(!mem_we_n));

  // R4: overlapping strobes end together
  p_strobe_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_we_n) |=> (mem_cs_n == mem_we_n));

  // R5: driver never on while the memory is selected for reading
  p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !mem_cs_n) |-> !mem_we_n);

  // R9: bus turnaround before the driver turns on
  p_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(csh_cnt) >= TURN_CYC));

  // R7: done lasts one cycle and sits inside busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R6: address stable throughout a transaction
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  // R3: read data only changes when a transaction completes
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW       (AW),
  .DW       (DW),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .rd_data   (rd_data)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WR_N   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RD_N   = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int TURN_N = (15 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_wr;
  logic [15:0] req_addr;
  logic [3:0]  req_wdata;
  logic [3:0]  rd_data;
  logic        done, busy;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_dq_o;
  logic [3:0]  mem_dq_i;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .done(done), .busy(busy), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  typedef struct {
    logic        cs_n, we_n, oe, busy, done, upd;
    logic [15:0] a;
    logic [3:0]  d, rv;
  } exp_t;

  exp_t        q[$];
  logic [3:0]  sram[int];
  logic [3:0]  ref_mem[int];
  logic [3:0]  exp_rd = 4'h0;
  int          hz_run = 0;
  logic        prev_oe = 1'b0;
  bit          model_on = 0;

  function automatic logic [3:0] look(ref logic [3:0] m[int], input int a);
    return m.exists(a) ? m[a] : 4'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(logic cs, logic we, logic oe, logic dn,
                              logic [15:0] a, logic [3:0] d, logic upd, logic [3:0] rv);
    exp_t e;
    e.cs_n = cs; e.we_n = we; e.oe = oe; e.busy = 1'b1; e.done = dn;
    e.a = a; e.d = d; e.upd = upd; e.rv = rv;
    return e;
  endfunction

  // Reference model: schedule of expected port values per cycle
  always @(posedge clk) begin
    if (model_on) begin
      bit was_empty;
      was_empty = (q.size() == 0);
      if (!was_empty) void'(q.pop_front());
      if (was_empty && req) begin
        if (req_wr) begin
          for (int i = 0; i < TURN_N; i++) q.push_back(mk(1, 0, 0, 0, req_addr, req_wdata, 0, 0));
          for (int i = 0; i < WR_N; i++)   q.push_back(mk(0, 0, 1, 0, req_addr, req_wdata, 0, 0));
          q.push_back(mk(1, 1, 1, 1, req_addr, req_wdata, 0, 0));
          ref_mem[int'(req_addr)] = req_wdata;
        end else begin
          for (int i = 0; i < RD_N; i++) q.push_back(mk(0, 1, 0, 0, req_addr, 4'h0, 0, 0));
          q.push_back(mk(1, 1, 0, 1, req_addr, 4'h0, 1, look(ref_mem, int'(req_addr))));
        end
      end
    end
    // Behavioural memory: a write lands while both strobes are low
    if (!mem_cs_n && !mem_we_n) sram[int'(mem_addr)] = mem_dq_o;
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      if (q.size() == 0) begin
        check(mem_cs_n && mem_we_n, "R2/R4 idle strobes", {mem_cs_n, mem_we_n}, 3);
        check(!mem_dq_oe, "R5 idle driver", mem_dq_oe, 0);
        check(!busy && !done, "R7 idle busy/done", {busy, done}, 0);
      end else begin
        exp_t e;
        e = q[0];
        check(mem_cs_n == e.cs_n && mem_we_n == e.we_n, "R2/R4 strobes",
              {mem_cs_n, mem_we_n}, {e.cs_n, e.we_n});
        check(mem_dq_oe == e.oe, "R5 driver enable", mem_dq_oe, e.oe);
        if (e.oe) check(mem_dq_o == e.d, "R5 write data", mem_dq_o, e.d);
        check(mem_addr == e.a, "R6 address", mem_addr, e.a);
        check(busy == e.busy && done == e.done, "R7 busy/done",
              {busy, done}, {e.busy, e.done});
        if (e.upd) exp_rd = e.rv;
      end
      check(rd_data == exp_rd, "R3 read data", rd_data, exp_rd);
      if (mem_dq_oe && !prev_oe) check(hz_run >= TURN_N, "R9 turnaround", hz_run, TURN_N);
    end
    prev_oe = mem_dq_oe;
    hz_run  = mem_cs_n ? hz_run + 1 : 0;
    mem_dq_i = (!mem_cs_n && mem_we_n) ? look(sram, int'(mem_addr)) : 4'hA;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic op(input logic wr, input logic [15:0] a, input logic [3:0] d);
    wait_idle();
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [3:0] v, input string tag);
    op(1'b0, a, 4'h0);
    wait_idle();
    check(rd_data == v, tag, rd_data, v);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    mem_dq_i = 4'hA;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && !mem_dq_oe && !busy && !done && rd_data == 4'h0,
          "R1 reset state", {mem_cs_n, mem_we_n, mem_dq_oe, busy, done, rd_data}, 6'b110000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_cs_n && mem_we_n && !busy, "R1 after release", {mem_cs_n, mem_we_n, busy}, 3'b110);
    model_on = 1;

    op(1'b1, 16'h0000, 4'h5);
    op(1'b1, 16'hFFFF, 4'hA);
    op(1'b1, 16'h1234, 4'h3);
    rd_expect(16'h0000, 4'h5, "R3 read addr 0");
    rd_expect(16'hFFFF, 4'hA, "R3 read top addr");
    rd_expect(16'h1234, 4'h3, "R3 read pattern");
    rd_expect(16'h0042, 4'h0, "R3 read unwritten");
    op(1'b1, 16'h0042, 4'hF);   // R9: write on first idle cycle after a read
    rd_expect(16'h0042, 4'hF, "R3 read after write");

    // R10: request held high for many cycles
    wait_idle();
    req = 1'b1; req_wr = 1'b0; req_addr = 16'h1234;
    repeat (14) @(negedge clk);
    req = 1'b0;
    wait_idle();
    req = 1'b1; req_wr = 1'b1; req_addr = 16'h7777; req_wdata = 4'h6;
    repeat (13) @(negedge clk);
    req = 1'b0;
    rd_expect(16'h7777, 4'h6, "R10 held write");

    // R8: request during busy is dropped
    op(1'b1, 16'h2000, 4'h9);
    req = 1'b1; req_wr = 1'b1; req_addr = 16'h3000; req_wdata = 4'hC;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    rd_expect(16'h3000, 4'h0, "R8 ignored write left memory unchanged");
    rd_expect(16'h2000, 4'h9, "R8 accepted write intact");

    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule